// File: doc/BRIEF.md
# Binary Synchronous Receive Character Processor

This block sits behind a bit deserialiser on the receive side of a byte-oriented binary synchronous link. It takes one received bit per strobed clock cycle. While unsynchronised it looks for two programmable sync characters back to back in the raw bit stream. The match fixes byte alignment, and from then on the block frames characters. Each character is eight data bits, least significant bit first, optionally followed by a parity bit.

Each framed character is checked for parity, and a wrapping error counter records failures. Characters equal to the configured idle-fill value or link-escape value are dropped. Every other character is delivered with a one-cycle valid strobe. With it come a flag and an index that tell whether the byte falls in one of eight programmable control-character classes, each defined under a shared bit mask. All configuration arrives on plain input ports. Dropping the channel enable sends the block back to hunting.

Top module: `bisync_rx_char`

## Requirements
- R1: While hunting, no output is produced. Synchronisation is reached when the last 16 received bits, taken LSB first, are `syn1_i` followed by `syn2_i`, with no parity bits between them. The sync characters themselves are never output.
- R2: Once synchronised, a character is 8 data bits LSB first, plus a ninth parity bit when `par_en_i` is 1. `data_vld_o` is high for exactly one cycle, in the clock cycle after the edge that samples the character's last bit, and `data_o` then holds the byte.
- R3: A framed byte equal to `sync_chr_i` is dropped and raises no `data_vld_o`.
- R4: A framed byte equal to `dle_chr_i` is dropped and raises no `data_vld_o`.
- R5: Entry i of `ctl_chr_i` sits in bits [8i+7:8i]. It matches a byte when `((byte ^ entry) & ctl_mask_i) == 0`. `ctl_hit_o` is raised together with `data_vld_o` when any entry matches, and `ctl_idx_o` gives the matching entry.
- R6: When several entries match, `ctl_idx_o` reports the lowest-numbered one.
- R7: With `par_odd_i` = 1, the nine bits must hold an odd number of ones; with 0, an even number. A mismatch increments `perr_cnt_o`. With `par_en_i` = 0, there is no parity bit and no count.
- R8: `perr_cnt_o` wraps from 0xFFFF to 0x0000.
- R9: `perr_ld_i` loads `perr_ld_val_i` into the counter only while `en_i` is 0. With `en_i` = 1 it has no effect.
- R10: Taking `en_i` low returns the block to hunting. After re-enable, characters give no output until sync is found again.
- R11: After reset, `data_vld_o`, `ctl_hit_o`, `data_o`, `ctl_idx_o` and `perr_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Channel enable |
| bit_i | input | 1 | Received bit |
| bit_vld_i | input | 1 | Strobe, bit_i valid this cycle |
| syn1_i | input | 8 | First sync character |
| syn2_i | input | 8 | Second sync character |
| sync_chr_i | input | 8 | Idle-fill character to drop |
| dle_chr_i | input | 8 | Link-escape character to drop |
| ctl_chr_i | input | 64 | Eight control-character entries |
| ctl_mask_i | input | 8 | Shared compare mask, 1 = bit compared |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| perr_ld_i | input | 1 | Load error counter (only when disabled) |
| perr_ld_val_i | input | 16 | Counter load value |
| data_vld_o | output | 1 | Data byte strobe |
| data_o | output | 8 | Received data byte |
| ctl_hit_o | output | 1 | Byte matched a control entry |
| ctl_idx_o | output | 3 | Index of matching entry |
| perr_cnt_o | output | 16 | Parity error count |

## Verification
Suppose the bit counter is misaligned after sync. Then the very first framed character comes out as a shifted byte, or its strobe lands a cycle off, so the fault shows within nine bit times of the sync pattern. A framing state stuck in hunt, or stuck in framed across a disable, shows as a missing or spurious strobe on the first character after enable. Errors in the mask or the priority show only on bytes that fall in a masked class or hit several entries at once, so the stimulus includes such bytes on purpose. Counter faults show in `perr_cnt_o` as early as the edge after the failing parity bit.

// File: rtl/bisync_rx_pkg.sv
package bisync_rx_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_FRAMED = 1'b1} rx_state_e;
endpackage

// File: rtl/bisync_sync_hunt.sv
module bisync_sync_hunt #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] syn1_i,
  input  logic [DATA_W-1:0] syn2_i,
  output logic              hit_o
);
  localparam int SH_W = 2 * DATA_W;

  logic [SH_W-1:0] sh_q, sh_nxt;

  // LSB first: newest bit enters at the top
  assign sh_nxt = {bit_i, sh_q[SH_W-1:1]};
  assign hit_o  = run_i && bit_vld_i && (sh_nxt == {syn2_i, syn1_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (!run_i)    sh_q <= '0;
    else if (bit_vld_i) sh_q <= sh_nxt;
  end
endmodule

// File: rtl/bisync_char_asm.sv
module bisync_char_asm #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              par_en_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              par_o
);
  localparam int CW = $clog2(DATA_W + 2);

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] byte_q;
  logic              last_data, in_data;

  assign last_data = (cnt_q == CW'(DATA_W - 1));
  assign in_data   = (cnt_q < CW'(DATA_W));
  assign done_o    = run_i && bit_vld_i &&
                     (par_en_i ? (cnt_q == CW'(DATA_W)) : last_data);
  assign byte_o    = last_data ? {bit_i, byte_q[DATA_W-1:1]} : byte_q;
  assign par_o     = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      byte_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
    end else if (bit_vld_i) begin
      cnt_q <= done_o ? '0 : cnt_q + CW'(1);
      if (in_data) byte_q <= {bit_i, byte_q[DATA_W-1:1]};
    end
  end
endmodule

// File: rtl/bisync_ctl_match.sv
module bisync_ctl_match #(
  parameter int DATA_W = 8,
  parameter int N_CTL  = 8,
  localparam int IDX_W = (N_CTL > 1) ? $clog2(N_CTL) : 1
) (
  input  logic [DATA_W-1:0]       byte_i,
  input  logic [N_CTL*DATA_W-1:0] ctl_chr_i,
  input  logic [DATA_W-1:0]       mask_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [N_CTL-1:0] eq;

  for (genvar g = 0; g < N_CTL; g++) begin : g_cmp
    assign eq[g] = ((byte_i ^ ctl_chr_i[g*DATA_W +: DATA_W]) & mask_i) == '0;
  end

  // lowest index wins: scan downward so the last write is the smallest
  always_comb begin
    hit_o = |eq;
    idx_o = '0;
    for (int i = N_CTL - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/bisync_perr_cnt.sv
module bisync_perr_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (ld_i)  cnt_o <= ld_val_i;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/bisync_rx_char.sv
module bisync_rx_char
  import bisync_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_CTL  = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (N_CTL > 1) ? $clog2(N_CTL) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    bit_i,
  input  logic                    bit_vld_i,
  input  logic [DATA_W-1:0]       syn1_i,
  input  logic [DATA_W-1:0]       syn2_i,
  input  logic [DATA_W-1:0]       sync_chr_i,
  input  logic [DATA_W-1:0]       dle_chr_i,
  input  logic [N_CTL*DATA_W-1:0] ctl_chr_i,
  input  logic [DATA_W-1:0]       ctl_mask_i,
  input  logic                    par_en_i,
  input  logic                    par_odd_i,
  input  logic                    perr_ld_i,
  input  logic [CNT_W-1:0]        perr_ld_val_i,
  output logic                    data_vld_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    ctl_hit_o,
  output logic [IDX_W-1:0]        ctl_idx_o,
  output logic [CNT_W-1:0]        perr_cnt_o
);
  rx_state_e         state_q;
  logic              hunt_run, frm_run, hunt_hit;
  logic              chr_done, chr_par, perr, strip, m_hit, keep;
  logic [DATA_W-1:0] chr_byte;
  logic [IDX_W-1:0]  m_idx;

  assign hunt_run = en_i && (state_q == ST_HUNT);
  assign frm_run  = en_i && (state_q == ST_FRAMED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_HUNT;
    else if (!en_i)    state_q <= ST_HUNT;
    else if (hunt_hit) state_q <= ST_FRAMED;
  end

  bisync_sync_hunt #(.DATA_W(DATA_W)) u_hunt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (hunt_run),
    .bit_vld_i(bit_vld_i),
    .bit_i    (bit_i),
    .syn1_i   (syn1_i),
    .syn2_i   (syn2_i),
    .hit_o    (hunt_hit)
  );

  bisync_char_asm #(.DATA_W(DATA_W)) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (frm_run),
    .bit_vld_i(bit_vld_i),
    .bit_i    (bit_i),
    .par_en_i (par_en_i),
    .done_o   (chr_done),
    .byte_o   (chr_byte),
    .par_o    (chr_par)
  );

  bisync_ctl_match #(.DATA_W(DATA_W), .N_CTL(N_CTL)) u_match (
    .byte_i   (chr_byte),
    .ctl_chr_i(ctl_chr_i),
    .mask_i   (ctl_mask_i),
    .hit_o    (m_hit),
    .idx_o    (m_idx)
  );

  // total ones over data+parity must equal par_odd_i
  assign perr  = par_en_i && ((^chr_byte ^ chr_par) != par_odd_i);
  assign strip = (chr_byte == sync_chr_i) || (chr_byte == dle_chr_i);
  assign keep  = chr_done && !strip;

  bisync_perr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (perr_ld_i && !en_i),
    .ld_val_i(perr_ld_val_i),
    .inc_i   (chr_done && perr),
    .cnt_o   (perr_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_vld_o <= 1'b0;
      ctl_hit_o  <= 1'b0;
      data_o     <= '0;
      ctl_idx_o  <= '0;
    end else begin
      data_vld_o <= keep;
      ctl_hit_o  <= keep && m_hit;
      if (keep) begin
        data_o    <= chr_byte;
        ctl_idx_o <= m_idx;
      end
    end
  end
endmodule

// File: rtl/bisync_rx_char_chk.sv
module bisync_rx_char_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              perr_ld_i,
  input logic [DATA_W-1:0] sync_chr_i,
  input logic [DATA_W-1:0] dle_chr_i,
  input logic              data_vld_o,
  input logic [DATA_W-1:0] data_o,
  input logic              ctl_hit_o,
  input logic [CNT_W-1:0]  perr_cnt_o
);
  p_vld_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |=> !data_vld_o);

  p_no_sync_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> data_o != $past(sync_chr_i));

  p_no_dle_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> data_o != $past(dle_chr_i));

  p_hit_with_vld_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_hit_o |-> data_vld_o);

  // R7 R8 R9: only +1 (wrapping) or hold unless a disabled-channel load
  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(perr_ld_i && !en_i) |=>
      (perr_cnt_o == $past(perr_cnt_o)) ||
      (perr_cnt_o == $past(perr_cnt_o) + CNT_W'(1)));

  p_quiet_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !data_vld_o);
endmodule

bind bisync_rx_char bisync_rx_char_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .perr_ld_i (perr_ld_i),
  .sync_chr_i(sync_chr_i),
  .dle_chr_i (dle_chr_i),
  .data_vld_o(data_vld_o),
  .data_o    (data_o),
  .ctl_hit_o (ctl_hit_o),
  .perr_cnt_o(perr_cnt_o)
);

// File: tb/bisync_rx_char_bench.sv
module bisync_rx_char_bench;
  localparam int CLK_PER = 10;
  localparam logic [7:0] SYN1 = 8'h32, SYN2 = 8'h16, SYNC = 8'h16, DLE = 8'h10;
  // {byte[13:6], bad_par[5], exp_vld[4], exp_hit[3], exp_idx[2:0]}
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {8'h41, 1'b0, 1'b1, 1'b1, 3'd5},
    {8'hA5, 1'b0, 1'b1, 1'b0, 3'd0},
    {8'h16, 1'b0, 1'b0, 1'b0, 3'd0},
    {8'h02, 1'b0, 1'b1, 1'b1, 3'd0},
    {8'h10, 1'b0, 1'b0, 1'b0, 3'd0},
    {8'h03, 1'b0, 1'b1, 1'b1, 3'd1},
    {8'h00, 1'b1, 1'b1, 1'b0, 3'd0},
    {8'hFF, 1'b0, 1'b1, 1'b1, 3'd7},
    {8'h5A, 1'b1, 1'b1, 1'b0, 3'd0}
  };

  logic        clk = 1'b0, rst_ni = 1'b0, en = 1'b0, bit_d = 1'b0, bit_vld = 1'b0;
  logic [63:0] ctl_chr = {8'hFF, 8'h61, 8'h41, 8'h2D, 8'h05, 8'h03, 8'h03, 8'h02};
  logic [7:0]  ctl_mask = 8'hFF;
  logic        par_en = 1'b1, par_odd = 1'b1, perr_ld = 1'b0;
  logic [15:0] perr_ld_val = 16'h0;
  logic        data_vld, ctl_hit;
  logic [7:0]  data;
  logic [2:0]  ctl_idx;
  logic [15:0] perr_cnt;
  int          n_chk = 0, n_err = 0;
  logic [15:0] exp_cnt = 16'h0;

  always #(CLK_PER / 2) clk = ~clk;

  bisync_rx_char u_bisync_rx_char (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .bit_i(bit_d), .bit_vld_i(bit_vld),
    .syn1_i(SYN1), .syn2_i(SYN2), .sync_chr_i(SYNC), .dle_chr_i(DLE),
    .ctl_chr_i(ctl_chr), .ctl_mask_i(ctl_mask), .par_en_i(par_en),
    .par_odd_i(par_odd), .perr_ld_i(perr_ld), .perr_ld_val_i(perr_ld_val),
    .data_vld_o(data_vld), .data_o(data), .ctl_hit_o(ctl_hit),
    .ctl_idx_o(ctl_idx), .perr_cnt_o(perr_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_d   = b;
    bit_vld = 1'b1;
  endtask

  task automatic send_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  // sends a character, then samples outputs in the cycle after the last bit
  task automatic send_chr(input logic [7:0] b, input logic bad);
    logic p;
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    if (par_en) begin
      p = par_odd ? ~^b : ^b;
      send_bit(bad ? ~p : p);
    end
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic do_sync();
    send_raw(SYN1);
    send_raw(SYN2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 vld", data_vld, 0);
    chk("R11 hit", ctl_hit, 0);
    chk("R11 data", data, 0);
    chk("R11 idx", ctl_idx, 0);
    chk("R11 cnt", perr_cnt, 0);
    rst_ni = 1'b1;
    en     = 1'b1;
    @(negedge clk);

    // R1: unsynchronised character gives nothing
    send_chr(8'h41, 1'b0);
    chk("R1 no output while hunting", data_vld, 0);
    send_raw(8'hC3);
    chk("R1 no output while hunting", data_vld, 0);
    do_sync();
    chk("R1 sync chars not output", data_vld, 0);

    // R2..R8 table walk
    for (int v = 0; v < NV; v++) begin
      send_chr(VEC[v][13:6], VEC[v][5]);
      if (VEC[v][5]) exp_cnt++;
      chk("R2 R3 R4 vld", data_vld, VEC[v][4]);
      if (VEC[v][4]) begin
        chk("R2 data", data, VEC[v][13:6]);
        chk("R5 hit", ctl_hit, VEC[v][3]);
        if (VEC[v][3]) chk("R5 R6 idx", ctl_idx, VEC[v][2:0]);
      end
      chk("R7 cnt", perr_cnt, exp_cnt);
      @(negedge clk);
      chk("R2 single-cycle strobe", data_vld, 0);
    end

    // R5: mask defines a class
    ctl_mask = 8'hF0;
    send_chr(8'h4C, 1'b0);
    chk("R5 class hit", ctl_hit, 1);
    chk("R5 class idx", ctl_idx, 5);
    send_chr(8'h07, 1'b0);
    chk("R6 class lowest idx", ctl_idx, 0);
    ctl_mask = 8'hFF;

    // R7: even parity, good and bad
    par_odd = 1'b0;
    send_chr(8'h37, 1'b0);
    chk("R7 even good", perr_cnt, exp_cnt);
    send_chr(8'h37, 1'b1);
    exp_cnt++;
    chk("R7 even bad", perr_cnt, exp_cnt);
    par_odd = 1'b1;

    // R7: parity disabled, 8-bit characters
    par_en = 1'b0;
    send_chr(8'h9E, 1'b0);
    chk("R7 no parity data", data, 8'h9E);
    chk("R7 no parity vld", data_vld, 1);
    chk("R7 no parity cnt", perr_cnt, exp_cnt);
    par_en = 1'b1;

    // R9: load ignored while enabled
    @(negedge clk);
    perr_ld_val = 16'h1234;
    perr_ld     = 1'b1;
    @(negedge clk);
    perr_ld = 1'b0;
    chk("R9 load ignored enabled", perr_cnt, exp_cnt);

    // R9 R8: load while disabled, then wrap
    en = 1'b0;
    @(negedge clk);
    perr_ld_val = 16'hFFFF;
    perr_ld     = 1'b1;
    @(negedge clk);
    perr_ld = 1'b0;
    chk("R9 load disabled", perr_cnt, 16'hFFFF);
    en = 1'b1;

    // R10: re-enabled but not synced
    send_chr(8'hA5, 1'b0);
    chk("R10 hunt after disable", data_vld, 0);
    do_sync();
    send_chr(8'h11, 1'b1);
    chk("R10 framed again", data_vld, 1);
    chk("R8 wrap", perr_cnt, 16'h0000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule